// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

The block watches the packed 32-bit time/date word of a calendar counter and raises an alarm flag when the word agrees with a programmed alarm word. A three-bit mask select picks how many of the six fields take part in the comparison. The lowest field, seconds, is always included when the alarm is on. Each higher field is added in turn: minutes, hours, day, month and year. The fields that are not picked are ignored.

The flag does not rise in the cycle where agreement appears. A three-state arming machine notes the agreement and raises the flag on the next count tick. At a 1 Hz count rate, this places the flag one second after the matching second began.

The states are named as follows:
- `ST_OFF`: the alarm is disabled.
- `ST_WAIT`: armed, with no agreement noted.
- `ST_SEEN`: agreement noted, waiting for the tick.

The transitions are named as follows:
- `OFF->WAIT`: the mask becomes active.
- `WAIT->SEEN`: agreement in a non-tick cycle.
- `SEEN->WAIT`: a tick sets the flag.
- `any->OFF`: the mask becomes inactive.
- `any->WAIT/OFF on write`: an alarm or mask write discards a noted agreement.

The flag is cleared by writing one. The interrupt output is the flag gated by an enable bit.

Top module: `calarm_top`

## Requirements
- R1: After reset, the flag, the interrupt, the alarm value, the mask value and the enable are all zero, and the machine is in `ST_OFF`.
- R2: The clock and alarm words share one packing: seconds [5:0], minutes [11:6], hours [16:12], day [21:17], month [25:22], year [31:26].
- R3: A mask select of n, where n is 1 to 6, compares the lowest n fields (seconds first) and ignores the rest. A mask select of 0 or 7 never produces a flag.
- R4: While the word agrees, the flag stays low until a count tick arrives. The flag is set at the first tick after the agreement has been noted in a cycle without a tick.
- R5: An agreement seen in a non-tick cycle is held until the next tick, even if the word changes before then. An agreement present only in a tick cycle is not noted.
- R6: A write to the alarm register or the mask register discards a noted agreement, so the next tick does not set the flag. This includes a tick in the same cycle as the write.
- R7: Asserting `flag_w1c` clears the flag. If a set and a clear occur in the same cycle, the set wins.
- R8: `alm_irq` is high exactly when the flag is high and the enable bit (written via `ien_wr`) is one.
- R9: `alm_value` and `msk_value` return the last values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle pulse per calendar count step |
| cal_word | input | 32 | Live packed time/date word |
| alm_wr | input | 1 | Alarm register write strobe |
| alm_wdata | input | 32 | Alarm word to write |
| msk_wr | input | 1 | Mask select write strobe |
| msk_wdata | input | 3 | Mask select to write |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 1 | Interrupt enable value |
| flag_w1c | input | 1 | Write-one-to-clear for the flag |
| alm_value | output | 32 | Current alarm word |
| msk_value | output | 3 | Current mask select |
| alm_flag | output | 1 | Alarm flag |
| alm_irq | output | 1 | Flag gated by the enable |

## Verification
The assertions assume that `cnt_tick` is a single-cycle pulse. They also assume that the live word changes only in the cycle after a tick, as a registered counter would drive it, so a noted agreement always belongs to the second the tick closes. The stimulus drives every input at the falling clock edge and changes `cal_word` only between ticks. It writes the configuration before each compare pattern, so no agreement left over from an earlier pattern can reach a later check.

// File: rtl/calarm_pkg.sv
package calarm_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_FIELDS = 6;
    localparam int SEL_W      = 3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEEN = 2'd2
    } arm_state_e;

    // field order: seconds, minutes, hours, day, month, year
    function automatic int fld_lsb(input int idx);
        case (idx)
            0: return 0;
            1: return 6;
            2: return 12;
            3: return 17;
            4: return 22;
            default: return 26;
        endcase
    endfunction

    function automatic int fld_width(input int idx);
        case (idx)
            0: return 6;
            1: return 6;
            2: return 5;
            3: return 5;
            4: return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/calarm_mask_decode.sv
module calarm_mask_decode
    import calarm_pkg::*;
#(
    parameter int N_FLD = NUM_FIELDS,
    parameter int SW    = SEL_W
) (
    input  logic [SW-1:0]    sel,
    output logic [N_FLD-1:0] field_en,
    output logic             alarm_on
);

    localparam int MAX_SEL = N_FLD;

    always_comb begin
        alarm_on = (int'(sel) >= 1) && (int'(sel) <= MAX_SEL);
    end

    for (genvar g = 0; g < N_FLD; g++) begin : g_en
        assign field_en[g] = alarm_on && (int'(sel) > g);
    end

endmodule

// File: rtl/calarm_field_cmp.sv
module calarm_field_cmp
    import calarm_pkg::*;
#(
    parameter int N_FLD = NUM_FIELDS,
    parameter int WW    = WORD_W
) (
    input  logic [WW-1:0]    word,
    input  logic [WW-1:0]    alarm,
    input  logic [N_FLD-1:0] field_en,
    output logic             hit
);

    logic [N_FLD-1:0] fld_eq;

    for (genvar g = 0; g < N_FLD; g++) begin : g_fld
        localparam int LSB = fld_lsb(g);
        localparam int WID = fld_width(g);
        assign fld_eq[g] = (word[LSB +: WID] == alarm[LSB +: WID]);
    end

    always_comb begin
        hit = (|field_en) && (&(fld_eq | ~field_en));
    end

endmodule

// File: rtl/calarm_arm_fsm.sv
module calarm_arm_fsm
    import calarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hit,
    input  logic       alarm_on,
    input  logic       cfg_wr,
    input  logic       cfg_on_next,
    output logic       set_pulse,
    output arm_state_e state
);

    arm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = cfg_on_next ? ST_WAIT : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  if (alarm_on) state_d = ST_WAIT;
                ST_WAIT: begin
                    if (!alarm_on)          state_d = ST_OFF;
                    else if (hit && !tick)  state_d = ST_SEEN;
                end
                ST_SEEN: begin
                    if (!alarm_on)  state_d = ST_OFF;
                    else if (tick)  state_d = ST_WAIT;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        set_pulse = (state_q == ST_SEEN) && tick && !cfg_wr;
        state     = state_q;
    end

    // R6: a configuration write never leaves a noted agreement behind
    p_write_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (state_q != ST_SEEN));

    // R3: a disabled alarm cannot reach the noted state
    p_off_never_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_on && !cfg_wr) |=> (state_q != ST_SEEN));

    // R5: a match during a tick cycle in WAIT is not noted
    p_tick_no_note_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && tick) |=> (state_q != ST_SEEN));

endmodule

// File: rtl/calarm_top.sv
module calarm_top
    import calarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_tick,
    input  logic [31:0] cal_word,
    input  logic        alm_wr,
    input  logic [31:0] alm_wdata,
    input  logic        msk_wr,
    input  logic [2:0]  msk_wdata,
    input  logic        ien_wr,
    input  logic        ien_wdata,
    input  logic        flag_w1c,
    output logic [31:0] alm_value,
    output logic [2:0]  msk_value,
    output logic        alm_flag,
    output logic        alm_irq
);

    logic [WORD_W-1:0]     alarm_q;
    logic [SEL_W-1:0]      mask_q;
    logic                  ien_q;
    logic                  flag_q;
    logic [NUM_FIELDS-1:0] en_cur, en_new;
    logic                  on_cur, on_new;
    logic                  hit;
    logic                  set_pulse;
    logic                  cfg_wr;
    logic                  cfg_on_next;
    arm_state_e            arm_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            mask_q  <= '0;
            ien_q   <= 1'b0;
        end else begin
            if (alm_wr) alarm_q <= alm_wdata;
            if (msk_wr) mask_q  <= msk_wdata;
            if (ien_wr) ien_q   <= ien_wdata;
        end
    end

    calarm_mask_decode #(.N_FLD(NUM_FIELDS), .SW(SEL_W)) u_dec_cur (
        .sel(mask_q), .field_en(en_cur), .alarm_on(on_cur)
    );

    calarm_mask_decode #(.N_FLD(NUM_FIELDS), .SW(SEL_W)) u_dec_new (
        .sel(msk_wdata), .field_en(en_new), .alarm_on(on_new)
    );

    calarm_field_cmp #(.N_FLD(NUM_FIELDS), .WW(WORD_W)) u_cmp (
        .word(cal_word), .alarm(alarm_q), .field_en(en_cur), .hit(hit)
    );

    always_comb begin
        cfg_wr      = alm_wr || msk_wr;
        cfg_on_next = msk_wr ? on_new : on_cur;
    end

    calarm_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .hit(hit),
        .alarm_on(on_cur), .cfg_wr(cfg_wr), .cfg_on_next(cfg_on_next),
        .set_pulse(set_pulse), .state(arm_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (set_pulse) flag_q <= 1'b1;
        else if (flag_w1c)  flag_q <= 1'b0;
    end

    always_comb begin
        alm_value = alarm_q;
        msk_value = mask_q;
        alm_flag  = flag_q;
        alm_irq   = flag_q && ien_q;
    end

    // R4: the flag only rises on a count tick
    p_flag_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(cnt_tick));

    // R4: a noted agreement plus a tick raises the flag
    p_seen_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_state == ST_SEEN && cnt_tick && !cfg_wr) |=> alm_flag);

    // R7: a clear without a tick drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_w1c && !cnt_tick) |=> !alm_flag);

    // R8: disabling the enable silences the interrupt
    p_ien_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !ien_wdata) |=> !alm_irq);

endmodule

// File: tb/test_calarm_top.sv
`timescale 1ns/1ps
module test_calarm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [31:0] cal_word = '0;
    logic        alm_wr = 1'b0;
    logic [31:0] alm_wdata = '0;
    logic        msk_wr = 1'b0;
    logic [2:0]  msk_wdata = '0;
    logic        ien_wr = 1'b0;
    logic        ien_wdata = 1'b0;
    logic        flag_w1c = 1'b0;
    logic [31:0] alm_value;
    logic [2:0]  msk_value;
    logic        alm_flag;
    logic        alm_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    calarm_top i_calarm_top (.*);

    // R2 packing
    function automatic logic [31:0] pk(input int yr, input int mo, input int dy,
                                       input int hr, input int mi, input int se);
        return {yr[5:0], mo[3:0], dy[4:0], hr[4:0], mi[5:0], se[5:0]};
    endfunction

    // {expect, sel, alarm, word}
    localparam int NV = 11;
    localparam logic [67:0] VEC [NV] = '{
        {1'b1, 3'd1, pk(3,4,5,6,7,30),   pk(9,9,9,9,9,30)},
        {1'b0, 3'd1, pk(3,4,5,6,7,30),   pk(3,4,5,6,7,31)},
        {1'b1, 3'd2, pk(1,1,1,1,5,30),   pk(2,2,2,2,5,30)},
        {1'b0, 3'd2, pk(1,1,1,1,5,30),   pk(1,1,1,1,6,30)},
        {1'b1, 3'd3, pk(1,1,1,13,5,30),  pk(1,1,9,13,5,30)},
        {1'b0, 3'd4, pk(1,1,8,13,5,30),  pk(1,1,9,13,5,30)},
        {1'b1, 3'd5, pk(10,12,31,23,59,59), pk(63,12,31,23,59,59)},
        {1'b1, 3'd6, pk(63,12,31,23,59,59), pk(63,12,31,23,59,59)},
        {1'b0, 3'd6, pk(62,12,31,23,59,59), pk(63,12,31,23,59,59)},
        {1'b0, 3'd0, pk(1,2,3,4,5,6),    pk(1,2,3,4,5,6)},
        {1'b0, 3'd7, pk(1,2,3,4,5,6),    pk(1,2,3,4,5,6)}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] alm);
        @(negedge clk);
        alm_wr = 1'b1; alm_wdata = alm; msk_wr = 1'b1; msk_wdata = sel; flag_w1c = 1'b1;
        @(negedge clk);
        alm_wr = 1'b0; msk_wr = 1'b0; flag_w1c = 1'b0;
    endtask

    task automatic tick1();
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 flag", {31'd0, alm_flag}, 32'd0);
        chk("R1 irq", {31'd0, alm_irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 alarm", alm_value, 32'd0);
        chk("R1 mask", {29'd0, msk_value}, 32'd0);

        // table of compare patterns, R2 and R3
        for (int i = 0; i < NV; i++) begin
            cal_word = VEC[i][31:0];
            cfg(VEC[i][66:64], VEC[i][63:32]);
            if (i == 0) begin
                chk("R9 alarm", alm_value, VEC[i][63:32]);
                chk("R9 mask", {29'd0, msk_value}, {29'd0, VEC[i][66:64]});
            end
            repeat (2) @(negedge clk);
            tick1();
            chk($sformatf("R2/R3 vec%0d", i), {31'd0, alm_flag}, {31'd0, VEC[i][67]});
        end

        // R4: no flag before a tick, flag at the tick
        cal_word = pk(0,1,1,0,0,10);
        cfg(3'd1, pk(0,1,1,0,0,10));
        repeat (5) @(negedge clk);
        chk("R4 no tick", {31'd0, alm_flag}, 32'd0);
        tick1();
        chk("R4 tick", {31'd0, alm_flag}, 32'd1);

        // R7: set wins over a same-cycle clear, then clear alone
        repeat (2) @(negedge clk);
        flag_w1c = 1'b1;
        tick1();
        flag_w1c = 1'b0;
        chk("R7 set wins", {31'd0, alm_flag}, 32'd1);
        @(negedge clk);
        flag_w1c = 1'b1;
        @(negedge clk);
        flag_w1c = 1'b0;
        chk("R7 clear", {31'd0, alm_flag}, 32'd0);

        // R8: interrupt gating
        ien_wr = 1'b1; ien_wdata = 1'b1;
        @(negedge clk);
        ien_wr = 1'b0;
        repeat (2) @(negedge clk);
        tick1();
        chk("R8 irq on", {31'd0, alm_irq}, 32'd1);
        ien_wr = 1'b1; ien_wdata = 1'b0;
        @(negedge clk);
        ien_wr = 1'b0;
        chk("R8 irq off", {31'd0, alm_irq}, 32'd0);
        chk("R8 flag kept", {31'd0, alm_flag}, 32'd1);

        // R6: alarm write discards a noted agreement
        cfg(3'd1, pk(0,1,1,0,0,10));
        repeat (2) @(negedge clk);
        alm_wr = 1'b1; alm_wdata = pk(0,1,1,0,0,10);
        cal_word = pk(0,1,1,0,0,11);
        @(negedge clk);
        alm_wr = 1'b0;
        tick1();
        chk("R6 alarm write", {31'd0, alm_flag}, 32'd0);

        // R6: mask write in the tick cycle discards it too
        cal_word = pk(0,1,1,0,0,10);
        repeat (3) @(negedge clk);
        msk_wr = 1'b1; msk_wdata = 3'd1;
        tick1();
        msk_wr = 1'b0;
        cal_word = pk(0,1,1,0,0,11);
        chk("R6 mask write", {31'd0, alm_flag}, 32'd0);

        // R5: transient agreement is held until the tick
        repeat (2) @(negedge clk);
        cal_word = pk(0,1,1,0,0,10);
        @(negedge clk);
        cal_word = pk(0,1,1,0,0,11);
        repeat (2) @(negedge clk);
        tick1();
        chk("R5 held", {31'd0, alm_flag}, 32'd1);
        flag_w1c = 1'b1;
        @(negedge clk);
        flag_w1c = 1'b0;

        // R5: agreement only in a tick cycle is not noted
        cal_word = pk(0,1,1,0,0,10);
        tick1();
        cal_word = pk(0,1,1,0,0,11);
        chk("R5 tick only a", {31'd0, alm_flag}, 32'd0);
        repeat (2) @(negedge clk);
        tick1();
        chk("R5 tick only b", {31'd0, alm_flag}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule